// File: doc/BRIEF.md
# Multi-Source Reset Generator

This block collects every reset request of a chip and turns it into separate reset outputs for the peripheral, core and backup register domains. The requests are:

- a brownout detector, which is also the block's own asynchronous root reset;
- the exits from standby and from shutdown;
- an external active-low reset pin;
- a windowed watchdog and an independent watchdog;
- a software request;
- a low-power security violation;
- an option-load request;
- a radio protocol error;
- a software request to reset the backup domain.

All request inputs are synchronized into the clock domain before use.

Internal system-reset causes pull the shared open-drain reset pin low. The pin is split into a drive-low enable and a sensed level. Internal causes are stretched to a minimum width of `STRETCH_CYCLES` clock cycles. An external low on the pin resets the system only for as long as it lasts. Sticky cause flags record why the chip was reset. A system reset leaves them set. A brownout, a shutdown exit or a one-cycle software clear pulse clears them.

Top module: `rst_hub`

## Requirements
- R1: While `brownout_i` is high, `pin_drive_o`, `core_rst_o` and `periph_rst_o` are 1, `bkp_rst_o` is 0 and `cause_o` is 9'b1. After `brownout_i` falls, these three outputs stay 1 until the STRETCH_CYCLES-th rising edge. On that edge they return to 0.
- R2: Each of these internal causes raises `pin_drive_o`, `core_rst_o` and `periph_rst_o` on the third rising edge after its input rises: windowed watchdog, independent watchdog, software, security violation, option load, radio error, shutdown exit. A request held for L cycles keeps the outputs high for exactly L-1+STRETCH_CYCLES cycles.
- R3: Each cause sets one flag bit of `cause_o`: bit 0 brownout/shutdown, bit 1 standby exit, bit 2 external pin, bit 3 windowed watchdog, bit 4 independent watchdog, bit 5 software, bit 6 security violation, bit 7 option load, bit 8 radio error.
- R4: An external low on `pin_level_i` lasting L cycles gives a `core_rst_o`/`periph_rst_o` pulse. The pulse starts on the third edge and lasts exactly L cycles. `pin_drive_o` stays 0 during it, and flag bit 2 is set.
- R5: The block's own drive of the pin, seen back on `pin_level_i`, never sets flag bit 2.
- R6: Standby exit asserts `core_rst_o` for L-1+STRETCH_CYCLES cycles, starting on the third edge. It does not assert `periph_rst_o` or `pin_drive_o`. It sets bit 1 and keeps the other flags.
- R7: Shutdown exit is stretched like any internal cause. It leaves `cause_o` equal to 9'b1.
- R8: Flags accumulate across system resets. A one-cycle `flag_clr_i` (clock domain) clears them all on the next edge. A cause that lands on the same edge is kept.
- R9: `bkp_rst_o` follows `bkp_req_i` three edges late. No other cause, including brownout, asserts it.
- R10: A brownout asserts the outputs at once, without a clock edge. Every reset output deasserts only on a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| brownout_i | input | 1 | Brownout detector, asynchronous root reset, active high |
| standby_exit_i | input | 1 | Standby exit event |
| shutdown_exit_i | input | 1 | Shutdown exit event |
| wwdg_i | input | 1 | Windowed watchdog expiry |
| iwdg_i | input | 1 | Independent watchdog expiry |
| sw_req_i | input | 1 | Software system reset request |
| lp_sec_i | input | 1 | Low-power security violation |
| opt_load_i | input | 1 | Option-load reset request |
| radio_err_i | input | 1 | Radio protocol error |
| bkp_req_i | input | 1 | Backup-domain reset request |
| pin_level_i | input | 1 | Sensed level of the reset pin, low = reset |
| flag_clr_i | input | 1 | Clear all cause flags (clock domain) |
| pin_drive_o | output | 1 | 1 pulls the open-drain reset pin low |
| core_rst_o | output | 1 | Core-domain reset |
| periph_rst_o | output | 1 | Peripheral-domain (system) reset |
| bkp_rst_o | output | 1 | Backup-domain reset |
| cause_o | output | 9 | Sticky reset-cause flags |

## Verification
The assertions assume that `flag_clr_i` is synchronous to `clk` and that the asynchronous requests stay steady for at least one full cycle. They also assume that the pin level comes back only through the block's own open-drain wiring. The bench therefore drives every input on falling edges and holds each request for a whole number of cycles. It models the pin as the wired-AND of the block's drive and an external pull-down. Random requests are issued one at a time, and each one completes its stretch before the next begins.

// File: rtl/rsth_pkg.sv
`timescale 1ns/1ps
package rsth_pkg;
    localparam int NCAUSE = 9;

    // flag bit positions are visible to software and must stay fixed
    typedef enum logic [3:0] {
        C_BOR   = 4'd0,
        C_STBY  = 4'd1,
        C_PIN   = 4'd2,
        C_WWDG  = 4'd3,
        C_IWDG  = 4'd4,
        C_SW    = 4'd5,
        C_LPSEC = 4'd6,
        C_OPT   = 4'd7,
        C_RADIO = 4'd8
    } cause_e;

    typedef logic [NCAUSE-1:0] cause_vec_t;

    typedef struct packed {
        logic bkp;
        logic radio;
        logic opt;
        logic lpsec;
        logic sw;
        logic iwdg;
        logic wwdg;
        logic shdn;
        logic stby;
    } req_t;

    localparam cause_vec_t BOR_ONLY = cause_vec_t'(1);

    function automatic cause_vec_t cause_mask(input cause_e c);
        return cause_vec_t'(1) << c;
    endfunction
endpackage

// File: rtl/rsth_sync.sv
`timescale 1ns/1ps
module rsth_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         arst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/rsth_stretch.sv
`timescale 1ns/1ps
module rsth_stretch #(
    parameter int   LEN = 640,
    parameter logic INIT_BUSY = 1'b1
) (
    input  logic clk,
    input  logic arst,
    input  logic trig,
    output logic busy_nxt
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LOADV = CW'(LEN);

    logic [CW-1:0] cnt_q, cnt_nxt;

    always_comb begin
        if (trig)              cnt_nxt = LOADV;
        else if (cnt_q != '0)  cnt_nxt = cnt_q - CW'(1);
        else                   cnt_nxt = '0;
    end

    assign busy_nxt = (cnt_nxt != '0);

    always_ff @(posedge clk or posedge arst) begin
        if (arst) cnt_q <= INIT_BUSY ? LOADV : '0;
        else      cnt_q <= cnt_nxt;
    end

    AST_STRETCH_RELOAD: assert property (@(posedge clk) disable iff (arst)
        trig |=> (cnt_q == LOADV)); // R2
    AST_STRETCH_COUNTDOWN: assert property (@(posedge clk) disable iff (arst)
        (cnt_q != '0 && !trig) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R2
endmodule

// File: rtl/rsth_flags.sv
`timescale 1ns/1ps
module rsth_flags
    import rsth_pkg::*;
(
    input  logic       clk,
    input  logic       arst,
    input  logic       clr,
    input  logic       bor_evt,
    input  cause_vec_t set_vec,
    output cause_vec_t flags_o
);
    always_ff @(posedge clk or posedge arst) begin
        if (arst)         flags_o <= BOR_ONLY;
        else if (bor_evt) flags_o <= BOR_ONLY;
        else              flags_o <= (clr ? '0 : flags_o) | set_vec;
    end

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (arst)
        (!clr && !bor_evt) |=> ((flags_o & $past(flags_o)) == $past(flags_o))); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (arst)
        (!bor_evt) |=> ((flags_o & $past(set_vec)) == $past(set_vec))); // R8
    AST_SHDN_BOR_ONLY: assert property (@(posedge clk) disable iff (arst)
        bor_evt |=> (flags_o == BOR_ONLY)); // R7
endmodule

// File: rtl/rst_hub.sv
`timescale 1ns/1ps
module rst_hub
    import rsth_pkg::*;
#(
    parameter int STRETCH_CYCLES = 640,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              brownout_i,
    input  logic              standby_exit_i,
    input  logic              shutdown_exit_i,
    input  logic              wwdg_i,
    input  logic              iwdg_i,
    input  logic              sw_req_i,
    input  logic              lp_sec_i,
    input  logic              opt_load_i,
    input  logic              radio_err_i,
    input  logic              bkp_req_i,
    input  logic              pin_level_i,
    input  logic              flag_clr_i,
    output logic              pin_drive_o,
    output logic              core_rst_o,
    output logic              periph_rst_o,
    output logic              bkp_rst_o,
    output logic [NCAUSE-1:0] cause_o
);
    req_t req_raw, req_s;
    logic pin_s;

    always_comb begin
        req_raw       = '0;
        req_raw.stby  = standby_exit_i;
        req_raw.shdn  = shutdown_exit_i;
        req_raw.wwdg  = wwdg_i;
        req_raw.iwdg  = iwdg_i;
        req_raw.sw    = sw_req_i;
        req_raw.lpsec = lp_sec_i;
        req_raw.opt   = opt_load_i;
        req_raw.radio = radio_err_i;
        req_raw.bkp   = bkp_req_i;
    end

    rsth_sync #(.W($bits(req_t)), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_req_sync (
        .clk(clk), .arst(brownout_i), .d(req_raw), .q(req_s));

    rsth_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk(clk), .arst(brownout_i), .d(pin_level_i), .q(pin_s));

    // every stretched (internal) system cause, shutdown exit included
    logic int_req;
    assign int_req = req_s.shdn | req_s.wwdg | req_s.iwdg | req_s.sw |
                     req_s.lpsec | req_s.opt | req_s.radio;

    logic sys_busy_nxt, stby_busy_nxt;

    rsth_stretch #(.LEN(STRETCH_CYCLES), .INIT_BUSY(1'b1)) u_sys_str (
        .clk(clk), .arst(brownout_i), .trig(int_req), .busy_nxt(sys_busy_nxt));

    rsth_stretch #(.LEN(STRETCH_CYCLES), .INIT_BUSY(1'b0)) u_stby_str (
        .clk(clk), .arst(brownout_i), .trig(req_s.stby), .busy_nxt(stby_busy_nxt));

    // own drive echoes back through the pin synchronizer; mask that window
    logic                   drive_q, core_q, periph_q, bkp_q;
    logic [SYNC_STAGES-1:0] drv_hist;
    logic                   ext_low, sys_nxt, core_nxt;

    assign ext_low  = ~pin_s & ~drive_q & ~(|drv_hist);
    assign sys_nxt  = sys_busy_nxt | ext_low;
    assign core_nxt = sys_nxt | stby_busy_nxt;

    always_ff @(posedge clk or posedge brownout_i) begin
        if (brownout_i) begin
            drive_q  <= 1'b1;
            periph_q <= 1'b1;
            core_q   <= 1'b1;
            bkp_q    <= 1'b0;
            drv_hist <= '1;
        end else begin
            drive_q  <= sys_busy_nxt;
            periph_q <= sys_nxt;
            core_q   <= core_nxt;
            bkp_q    <= req_s.bkp;
            drv_hist <= SYNC_STAGES'({drv_hist, drive_q});
        end
    end

    cause_vec_t set_vec, flags;

    always_comb begin
        set_vec          = '0;
        set_vec[C_STBY]  = req_s.stby;
        set_vec[C_PIN]   = ext_low;
        set_vec[C_WWDG]  = req_s.wwdg;
        set_vec[C_IWDG]  = req_s.iwdg;
        set_vec[C_SW]    = req_s.sw;
        set_vec[C_LPSEC] = req_s.lpsec;
        set_vec[C_OPT]   = req_s.opt;
        set_vec[C_RADIO] = req_s.radio;
    end

    rsth_flags u_flags (
        .clk(clk), .arst(brownout_i), .clr(flag_clr_i),
        .bor_evt(req_s.shdn), .set_vec(set_vec), .flags_o(flags));

    assign pin_drive_o  = drive_q;
    assign core_rst_o   = core_q;
    assign periph_rst_o = periph_q;
    assign bkp_rst_o    = bkp_q;
    assign cause_o      = flags;

    AST_INT_DRIVES_PIN: assert property (@(posedge clk) disable iff (brownout_i)
        int_req |=> pin_drive_o); // R2
    AST_DRIVE_IN_PERIPH: assert property (@(posedge clk) disable iff (brownout_i)
        pin_drive_o |-> periph_rst_o); // R2
    AST_PERIPH_IN_CORE: assert property (@(posedge clk) disable iff (brownout_i)
        periph_rst_o |-> core_rst_o); // R6
    AST_OWN_DRIVE_NO_PIN_FLAG: assert property (@(posedge clk) disable iff (brownout_i)
        (drive_q && !cause_o[C_PIN]) |=> !cause_o[C_PIN]); // R5
    AST_BKP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (brownout_i)
        req_s.bkp |=> bkp_rst_o); // R9
    AST_BKP_QUIET: assert property (@(posedge clk) disable iff (brownout_i)
        !req_s.bkp |=> !bkp_rst_o); // R9
endmodule

// File: tb/rst_hub_tb.sv
`timescale 1ns/1ps
module rst_hub_tb;
    import rsth_pkg::*;

    localparam int STR = 12;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic bor = 1'b0, stby = 1'b0, shdn = 1'b0, wwdg = 1'b0, iwdg = 1'b0, sw = 1'b0;
    logic lps = 1'b0, opt = 1'b0, rad = 1'b0, bkp = 1'b0, ext_low = 1'b0, clr = 1'b0;
    logic pin_drv, core_rst, per_rst, bkp_rst, pin_lvl;
    logic [NCAUSE-1:0] flags;

    assign pin_lvl = ~(pin_drv | ext_low);

    rst_hub #(.STRETCH_CYCLES(STR), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .brownout_i(bor), .standby_exit_i(stby), .shutdown_exit_i(shdn),
        .wwdg_i(wwdg), .iwdg_i(iwdg), .sw_req_i(sw), .lp_sec_i(lps), .opt_load_i(opt),
        .radio_err_i(rad), .bkp_req_i(bkp), .pin_level_i(pin_lvl), .flag_clr_i(clr),
        .pin_drive_o(pin_drv), .core_rst_o(core_rst), .periph_rst_o(per_rst),
        .bkp_rst_o(bkp_rst), .cause_o(flags));

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    cause_vec_t exp_fl;
    int f_drv, f_core, f_per, f_bkp, c_drv, c_core, c_per, c_bkp;

    task automatic check(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic cause_vec_t flag_update(input cause_vec_t f, input int c);
        if (c == C_BOR) return BOR_ONLY;
        return f | cause_mask(cause_e'(c));
    endfunction

    function automatic int stretch_len(input int hold);
        return hold - 1 + STR;
    endfunction

    // kind 0: cause c (C_BOR means shutdown exit), 1: external pin, 2: backup request
    task automatic drive_src(input int kind, input int c, input logic v);
        if (kind == 1) ext_low = v;
        else if (kind == 2) bkp = v;
        else begin
            case (c)
                C_BOR:   shdn = v;
                C_STBY:  stby = v;
                C_WWDG:  wwdg = v;
                C_IWDG:  iwdg = v;
                C_SW:    sw   = v;
                C_LPSEC: lps  = v;
                C_OPT:   opt  = v;
                default: rad  = v;
            endcase
        end
    endtask

    task automatic pulse_measure(input int kind, input int c, input int hold);
        f_drv = -1; f_core = -1; f_per = -1; f_bkp = -1;
        c_drv = 0; c_core = 0; c_per = 0; c_bkp = 0;
        @(negedge clk);
        drive_src(kind, c, 1'b1);
        for (int k = 1; k <= hold + STR + 6; k++) begin
            @(negedge clk);
            if (pin_drv)  begin c_drv++;  if (f_drv  < 0) f_drv  = k; end
            if (core_rst) begin c_core++; if (f_core < 0) f_core = k; end
            if (per_rst)  begin c_per++;  if (f_per  < 0) f_per  = k; end
            if (bkp_rst)  begin c_bkp++;  if (f_bkp  < 0) f_bkp  = k; end
            if (k == hold) drive_src(kind, c, 1'b0);
        end
    endtask

    task automatic run_internal(input int c, input int hold);
        pulse_measure(0, c, hold);
        exp_fl = flag_update(exp_fl, c);
        check("R2", f_drv, 3, "pin drive start edge");
        check("R2", c_drv, stretch_len(hold), "pin drive length");
        check("R2", c_per, stretch_len(hold), "periph reset length");
        check("R2", c_core, stretch_len(hold), "core reset length");
        check("R3", int'(flags), int'(exp_fl), "cause flags");
    endtask

    task automatic run_ext(input int hold);
        pulse_measure(1, 0, hold);
        exp_fl = flag_update(exp_fl, C_PIN);
        check("R4", f_per, 3, "ext reset start edge");
        check("R4", c_per, hold, "ext periph length");
        check("R4", c_core, hold, "ext core length");
        check("R4", c_drv, 0, "no pin drive on ext");
        check("R4", int'(flags), int'(exp_fl), "pin flag");
    endtask

    task automatic run_stby(input int hold);
        pulse_measure(0, C_STBY, hold);
        exp_fl = flag_update(exp_fl, C_STBY);
        check("R6", f_core, 3, "standby core start");
        check("R6", c_core, stretch_len(hold), "standby core length");
        check("R6", c_per, 0, "standby periph untouched");
        check("R6", c_drv, 0, "standby pin untouched");
        check("R6", int'(flags), int'(exp_fl), "standby flag kept others");
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        exp_fl = '0;
        check("R8", int'(flags), 0, "flags after clear");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        #1 bor = 1'b1;
        bkp = 1'b1;
        #1;
        // R10: asynchronous assertion, no clock edge yet
        check("R10", pin_drv, 1, "async drive on brownout");
        check("R1", core_rst, 1, "core in brownout");
        check("R1", per_rst, 1, "periph in brownout");
        check("R1", bkp_rst, 0, "backup untouched by brownout");
        check("R1", int'(flags), 1, "flags reset value");
        repeat (3) @(negedge clk);
        check("R9", bkp_rst, 0, "backup held off during brownout");
        bkp = 1'b0;
        bor = 1'b0;
        begin
            int hi = 0;
            for (int k = 1; k <= STR + 4; k++) begin
                @(negedge clk);
                if (per_rst) hi++;
            end
            check("R1", hi, STR - 1, "release stretch");
            check("R10", pin_drv, 0, "drive released on edge");
        end
        exp_fl = BOR_ONLY;

        // directed corners
        run_internal(C_WWDG, 1);
        run_internal(C_SW, 3);
        check("R5", int'(flags[C_PIN]), 0, "own drive leaves pin flag");
        run_ext(5);
        run_stby(2);
        run_internal(C_BOR, 1);
        check("R7", int'(flags), 1, "shutdown leaves BOR only");
        run_internal(C_RADIO, 2);
        check("R8", int'(flags), int'(cause_mask(C_BOR) | cause_mask(C_RADIO)), "sticky across reset");

        // clear colliding with a new cause on the same edge
        @(negedge clk); iwdg = 1'b1;
        @(negedge clk); iwdg = 1'b0;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        exp_fl = cause_mask(C_IWDG);
        check("R8", int'(flags), int'(exp_fl), "set wins over clear");
        repeat (STR + 4) @(negedge clk);
        do_clear();

        // backup domain request
        pulse_measure(2, 0, 2);
        check("R9", f_bkp, 3, "backup start edge");
        check("R9", c_bkp, 2, "backup length");
        check("R9", c_core, 0, "backup leaves core");

        // constrained random mix
        for (int it = 0; it < 40; it++) begin
            int kind = $urandom_range(0, 9);
            int hold = $urandom_range(1, 4);
            if (kind <= 5)      run_internal(C_WWDG + kind, hold);
            else if (kind == 6) run_ext(hold);
            else if (kind == 7) run_stby(hold);
            else if (kind == 8) run_internal(C_BOR, hold);
            else                do_clear();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule